// File: doc/BRIEF.md
# Chroma 4:2:2 to 4:4:4 Interpolator

This block takes a luma stream together with a single chroma bus that alternates blue-difference and red-difference samples, and produces one full pixel per accepted clock with luma, blue chroma and red chroma all present. Each chroma pair is shared by two neighbouring luma samples. The missing chroma is not filtered. The most recent complete pair is repeated for both pixels it belongs to.

A one-bit sync pulse marks the start of the stream. It fixes the clock on which the first sample is captured, and it fixes which chroma phase that sample carries. An active-low enable, registered inside the block, freezes every stage while it is high. A pass-through configuration forwards three independent component buses with the same pipeline delay, and sync has no effect in it. The block is meant to sit between a 4:2:2 video source and logic that needs 4:4:4 pixels.

Top module: `chroma_upsampler`

## Requirements
- R1: While and right after reset, `y_out`, `cb_out` and `cr_out` are zero and `out_valid` is low.
- R2: `en_n` is sampled by one register. A level of `en_n` present at rising edge k allows or blocks advancing at edge k+1. After `en_n` returns low, the first edge that advances is therefore the second rising edge. On a blocked edge no state changes and all outputs hold.
- R3: `sync` is sampled only on advancing edges. The second advancing edge after `sync` is first seen high captures the first sample. That sample is Cb, taken together with its luma. After that, advancing edges alternate Cr, Cb, Cr, and so on. Keeping `sync` high starts nothing further.
- R4: A captured Cb is held until the next Cr arrives. Both are then presented together: `cb_out` and `cr_out` change on the same edge.
- R5: Each chroma pair stays on the outputs for two advancing edges, alongside the two luma samples Y(N) and Y(N+1) that it belongs to. There is no filtering.
- R6: In interpolation, `y_out` is the luma accepted two advancing edges earlier.
- R7: In interpolation, `out_valid` stays low until the first complete Cb/Cr pair after a sync has been captured. It then stays high until reset or a mode change.
- R8: A new sync rise in the middle of a stream restarts the phase: its capture edge takes a Cb again. The previous pair stays on the outputs until the next Cr.
- R9: In pass-through, `y_in`, `c_in` and `cb_in` appear on `y_out`, `cr_out` and `cb_out` two advancing edges later. `out_valid` rises after two advancing edges, and `sync` has no effect.
- R10: Interpolation is selected only when `mode` = 3'b001 and `dir` = 1. Every other combination selects pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Active-low enable, registered before use |
| dir | input | 1 | 1 selects the inverse (interpolating) direction |
| mode | input | 3 | 3'b001 selects 4:2:2 handling; other codes select pass-through |
| sync | input | 1 | Stream start pulse; its rise fixes capture and phase |
| y_in | input | W | Luma input |
| c_in | input | W | Multiplexed chroma input (red chroma in pass-through) |
| cb_in | input | W | Blue chroma input, used only in pass-through |
| y_out | output | W | Delayed luma |
| cb_out | output | W | Blue chroma of the current pixel |
| cr_out | output | W | Red chroma of the current pixel |
| out_valid | output | 1 | Outputs carry a valid pixel |

## Verification
Two events can fall on the same clock: a stall taking effect, and either a sync-driven capture or a pair completion. Another case is a fresh sync rise on exactly the edge where a Cr was expected. The bench provokes these by pseudo-random `en_n` gaps laid over sync pulses, and by a second sync placed on an odd offset. Its behavioural model rebuilds the expected pixel from the history of accepted samples and compares it on every clock. A blocked edge is judged by requiring every output to hold, and a collided resync by requiring a Cb capture with the old pair still shown.

// File: rtl/cu_pkg.sv
package cu_pkg;
  localparam logic [2:0] MODE_PASS = 3'b000;
  localparam logic [2:0] MODE_422  = 3'b001;

  // interpolation is active only for the 4:2:2 code in the inverse direction
  function automatic logic interp_sel(input logic [2:0] m, input logic d);
    return (m == MODE_422) && d;
  endfunction

  // number of advancing edges between a luma capture and its output
  localparam int unsigned PIPE_LAG = 2;
endpackage

// File: rtl/cu_enable.sv
module cu_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic en_n,
  output logic ce
);
  logic en_q;
  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= ~en_n;
  end
  assign ce = en_q;
endmodule

// File: rtl/cu_delay.sv
module cu_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)  stg[0] <= '0;
        else if (ce) stg[0] <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n)  stg[i] <= '0;
        else if (ce) stg[i] <= stg[i-1];
      end
    end
  end
  assign q = stg[DEPTH-1];
endmodule

// File: rtl/cu_sync_phase.sv
module cu_sync_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic interp,
  input  logic sync,
  output logic start_evt,
  output logic cb_slot,
  output logic cr_slot,
  output logic expect_cr
);
  logic s1, s2, armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else if (ce) begin
      s1 <= sync;
      s2 <= s1;
    end
  end

  // second advancing edge after the sync rise
  assign start_evt = ce && interp && s1 && !s2;
  assign cb_slot   = ce && interp && (start_evt || (armed && !expect_cr));
  assign cr_slot   = ce && interp && !start_evt && armed && expect_cr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      expect_cr <= 1'b0;
    end else if (ce) begin
      if (!interp) begin
        armed     <= 1'b0;
        expect_cr <= 1'b0;
      end else if (start_evt) begin
        armed     <= 1'b1;
        expect_cr <= 1'b1;
      end else if (armed) begin
        expect_cr <= ~expect_cr;
      end
    end
  end
endmodule

// File: rtl/cu_chroma_pair.sv
module cu_chroma_pair #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         interp,
  input  logic         cb_slot,
  input  logic         cr_slot,
  input  logic [W-1:0] c_in,
  output logic [W-1:0] cb_hold,
  output logic [W-1:0] pair_cb,
  output logic [W-1:0] pair_cr,
  output logic         pair_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n)       cb_hold <= '0;
    else if (cb_slot) cb_hold <= c_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_cb    <= '0;
      pair_cr    <= '0;
      pair_valid <= 1'b0;
    end else if (cr_slot) begin
      pair_cb    <= cb_hold;
      pair_cr    <= c_in;
      pair_valid <= 1'b1;
    end else if (ce && !interp) begin
      pair_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/chroma_upsampler.sv
module chroma_upsampler #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_n,
  input  logic         dir,
  input  logic [2:0]   mode,
  input  logic         sync,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] c_in,
  input  logic [W-1:0] cb_in,
  output logic [W-1:0] y_out,
  output logic [W-1:0] cb_out,
  output logic [W-1:0] cr_out,
  output logic         out_valid
);
  import cu_pkg::*;

  localparam int unsigned LAG = PIPE_LAG;

  logic ce, interp;
  logic start_evt, cb_slot, cr_slot, expect_cr;
  logic [W-1:0] cb_hold, pair_cb, pair_cr;
  logic         pair_valid;
  logic [W-1:0] y_d, cb_d, cr_d;
  logic         pass_valid;

  assign interp = interp_sel(mode, dir);

  cu_enable u_en (.clk(clk), .rst_n(rst_n), .en_n(en_n), .ce(ce));

  cu_sync_phase u_phase (
    .clk(clk), .rst_n(rst_n), .ce(ce), .interp(interp), .sync(sync),
    .start_evt(start_evt), .cb_slot(cb_slot), .cr_slot(cr_slot),
    .expect_cr(expect_cr)
  );

  cu_chroma_pair #(.W(W)) u_pair (
    .clk(clk), .rst_n(rst_n), .ce(ce), .interp(interp),
    .cb_slot(cb_slot), .cr_slot(cr_slot), .c_in(c_in),
    .cb_hold(cb_hold), .pair_cb(pair_cb), .pair_cr(pair_cr),
    .pair_valid(pair_valid)
  );

  // luma lag balances the wait for the matching Cr
  cu_delay #(.W(W), .DEPTH(LAG)) u_ydly (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(y_in), .q(y_d));
  cu_delay #(.W(W), .DEPTH(LAG)) u_cbdly (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(cb_in), .q(cb_d));
  cu_delay #(.W(W), .DEPTH(LAG)) u_crdly (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(c_in), .q(cr_d));
  cu_delay #(.W(1), .DEPTH(LAG)) u_vdly (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(1'b1), .q(pass_valid));

  always_comb begin
    y_out = y_d;
    if (interp) begin
      cb_out    = pair_cb;
      cr_out    = pair_cr;
      out_valid = pair_valid;
    end else begin
      cb_out    = cb_d;
      cr_out    = cr_d;
      out_valid = pass_valid;
    end
  end
endmodule

// File: rtl/chroma_upsampler_chk.sv
module chroma_upsampler_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_n,
  input logic         ce,
  input logic         interp,
  input logic         dir,
  input logic [2:0]   mode,
  input logic         start_evt,
  input logic         cb_slot,
  input logic         cr_slot,
  input logic         expect_cr,
  input logic [W-1:0] c_in,
  input logic [W-1:0] cb_hold,
  input logic [W-1:0] y_out,
  input logic [W-1:0] cb_out,
  input logic [W-1:0] cr_out,
  input logic         out_valid
);
  assert_en_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> !ce);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce ##1 ($stable(mode) && $stable(dir))) |->
      ($stable(y_out) && $stable(cb_out) && $stable(cr_out) && $stable(out_valid)));

  assert_start_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> expect_cr);

  assert_pair_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_slot ##1 interp) |-> (cr_out == $past(c_in)) && (cb_out == $past(cb_hold)));

  assert_no_double_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cr_slot |=> !cr_slot);

  assert_valid_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && interp && $past(interp)) |-> $past(cr_slot));

  assert_pass_no_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !interp |-> (!start_evt && !cb_slot && !cr_slot));
endmodule

bind chroma_upsampler chroma_upsampler_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_n(en_n), .ce(ce), .interp(interp),
  .dir(dir), .mode(mode), .start_evt(start_evt), .cb_slot(cb_slot),
  .cr_slot(cr_slot), .expect_cr(expect_cr), .c_in(c_in), .cb_hold(cb_hold),
  .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out), .out_valid(out_valid)
);

// File: tb/tb_chroma_upsampler.sv
`timescale 1ns/1ps
module tb_chroma_upsampler;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, en_n, dir, sync;
  logic [2:0] mode;
  logic [W-1:0] y_in, c_in, cb_in;
  logic [W-1:0] y_out, cb_out, cr_out;
  logic out_valid;

  always #5 clk = ~clk;

  chroma_upsampler #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir), .mode(mode),
    .sync(sync), .y_in(y_in), .c_in(c_in), .cb_in(cb_in),
    .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out), .out_valid(out_valid)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_tag = "R3";

  // behavioural model: history of accepted samples
  int q_y[$], q_c[$], q_cb[$], q_s[$];
  bit m_ce, m_armed, m_interp;
  int m_idx;
  int e_y, e_cb, e_cr, e_pcb, e_pcr;
  bit e_pv, e_v;
  bit last_acc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_accept(input int y, input int c, input int cb, input bit s);
    int n;
    bit p1, p2, st, iscr;
    n  = q_s.size();
    p1 = (n >= 1) ? bit'(q_s[n-1]) : 1'b0;
    p2 = (n >= 2) ? bit'(q_s[n-2]) : 1'b0;
    st = m_interp && p1 && !p2;
    if (!m_interp) begin m_armed = 0; m_idx = 0; end
    else if (st) begin m_armed = 1; m_idx = 0; end
    else if (m_armed) m_idx++;
    iscr = m_interp && m_armed && !st && (m_idx % 2 == 1);
    if (iscr) begin e_pcb = q_c[n-1]; e_pcr = c; e_pv = 1; end
    if (!m_interp) e_pv = 0;
    q_y.push_back(y); q_c.push_back(c); q_cb.push_back(cb); q_s.push_back(int'(s));
    n = q_y.size();
    e_y = (n >= 2) ? q_y[n-2] : 0;
    if (m_interp) begin
      e_cb = e_pcb; e_cr = e_pcr; e_v = e_pv;
    end else begin
      e_cb = (n >= 2) ? q_cb[n-2] : 0;
      e_cr = (n >= 2) ? q_c[n-2]  : 0;
      e_v  = (n >= 2);
    end
  endtask

  task automatic do_reset(input logic [2:0] md, input logic dr);
    rst_n = 0; en_n = 0; sync = 0; mode = md; dir = dr;
    y_in = 0; c_in = 0; cb_in = 0;
    q_y.delete(); q_c.delete(); q_cb.delete(); q_s.delete();
    m_ce = 0; m_armed = 0; m_idx = 0; m_interp = (md == 3'b001) && dr;
    e_y = 0; e_cb = 0; e_cr = 0; e_pcb = 0; e_pcr = 0; e_pv = 0; e_v = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(y_out == 0 && cb_out == 0 && cr_out == 0, "R1", "reset data",
        int'(y_out) + int'(cb_out) + int'(cr_out), 0);
    chk(out_valid == 0, "R1", "reset valid", int'(out_valid), 0);
    rst_n = 1;
  endtask

  task automatic step(input bit en_v, input bit s_v);
    logic [W-1:0] py, pcb, pcr;
    logic pv;
    int yv, cv, bv;
    yv = $urandom_range(0, 255); cv = $urandom_range(0, 255); bv = $urandom_range(0, 255);
    py = y_out; pcb = cb_out; pcr = cr_out; pv = out_valid;
    en_n = en_v; sync = s_v; y_in = W'(yv); c_in = W'(cv); cb_in = W'(bv);
    last_acc = m_ce;
    if (m_ce) model_accept(yv, cv, bv, s_v);
    m_ce = !en_v;
    @(posedge clk);
    @(negedge clk);
    if (!last_acc) begin
      chk(y_out == py && cb_out == pcb && cr_out == pcr && out_valid == pv,
          "R2", "hold on blocked edge", int'(y_out), int'(py));
    end
    chk(out_valid == e_v, m_interp ? "R7" : "R9", "valid", int'(out_valid), int'(e_v));
    if (e_v) begin
      chk(int'(y_out) == e_y, m_interp ? "R6" : "R9", "luma", int'(y_out), e_y);
      chk(int'(cb_out) == e_cb, cur_tag, "cb", int'(cb_out), e_cb);
      chk(int'(cr_out) == e_cr, cur_tag, "cr", int'(cr_out), e_cr);
    end
  endtask

  initial begin
    // R3/R4/R5: clean stream, sync pulse, continuous enable
    cur_tag = "R3/R4/R5";
    do_reset(3'b001, 1'b1);
    repeat (3) step(0, 0);
    step(0, 1);
    for (int i = 0; i < 40; i++) step(0, 0);
    // sync held high for many cycles: only the rise counts (R3)
    for (int i = 0; i < 12; i++) step(0, 1);
    for (int i = 0; i < 10; i++) step(0, 0);

    // R2: random stalls overlapping sync and pair completion
    cur_tag = "R2/R4";
    do_reset(3'b001, 1'b1);
    step(0, 0); step(0, 1); step(1, 0); step(0, 0);
    for (int i = 0; i < 120; i++) step(($urandom_range(0, 9) < 3), (i % 37 == 5));
    for (int i = 0; i < 5; i++) step(1, 0);
    for (int i = 0; i < 6; i++) step(0, 0);

    // R8: resync on an odd offset, landing on an expected-Cr edge
    cur_tag = "R8";
    do_reset(3'b001, 1'b1);
    step(0, 1);
    for (int i = 0; i < 8; i++) step(0, 0);
    step(0, 1);
    for (int i = 0; i < 7; i++) step(0, 0);
    step(0, 1);
    for (int i = 0; i < 20; i++) step(0, 0);

    // R9: pass-through with sync toggling and stalls
    cur_tag = "R9";
    do_reset(3'b000, 1'b1);
    for (int i = 0; i < 60; i++) step(($urandom_range(0, 9) < 2), bit'($urandom_range(0, 1)));

    // R10: 4:2:2 code in forward direction, and an unused code
    cur_tag = "R10";
    do_reset(3'b001, 1'b0);
    for (int i = 0; i < 30; i++) step(0, (i == 3));
    do_reset(3'b101, 1'b1);
    for (int i = 0; i < 30; i++) step(0, (i == 3));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule